// File: doc/BRIEF.md
# TDM Serial Stream Channel Interface

This block is a slave port on a 32-channel time-division serial bus. A double-rate bit clock and an active-low frame pulse come in as plain inputs. The block samples them in its own system clock domain and finds their edges. It also tracks the frame boundary and counts bit-cells and channels. Incoming serial data is assembled into 8-bit bytes, and each byte is handed out with its channel number. For outgoing data the block asks, one channel ahead, for the next byte and a drive flag. It then shifts that byte onto the outgoing line and enables the line only for the channels that were given a drive flag.

Each bit-cell spans two bit-clock periods, and a cell begins on a falling bit-clock edge. A frame holds 32 channels of 8 cells each, which is 512 bit-clock periods. The frame pulse is sampled low at a falling bit-clock edge, and that edge begins cell 0 of channel 0. Incoming bits are taken at the rising edge three quarters of the way through a cell. Outgoing bits change at the start of a cell. A pulse that arrives early or late realigns the counters and raises a slip flag.

Top module: `tdm_channel_port`

## Requirements
- R1: During and straight after reset, `rx_valid_o`, `tx_req_o`, `tx_oe_o` and `slip_o` are all 0.
- R2: Until the first frame pulse is seen low at a falling bit-clock edge, the block issues no receive strobe and no transmit request, and it keeps `tx_oe_o` low.
- R3: Received bits are sampled at the second rising bit-clock edge of each cell, most significant bit first. After the eighth bit of a channel, `rx_valid_o` pulses for one system cycle. The byte appears on `rx_byte_o` and the channel number on `rx_ch_o`. Channel 0 is the first channel after the frame boundary.
- R4: At the start of the last cell of each channel, `tx_req_o` pulses for one cycle with the index of the next channel on `tx_req_ch_o`. A `tx_load_i` pulse before the next cell start stores `tx_byte_i` and `tx_drive_i` for that channel.
- R5: For a channel loaded with `tx_drive_i` = 1, `tx_oe_o` is 1 for all eight cells. `tx_sd_o` carries the stored byte most significant bit first, and each bit changes at a falling bit-clock edge that starts a cell.
- R6: For a channel that was not loaded, or was loaded with `tx_drive_i` = 0, `tx_oe_o` stays 0 for that channel. A drive flag applies to one channel only.
- R7: The frame has 256 cells, and the position count wraps on its own. If a frame pulse is missing, reception and transmission carry on in the same alignment and no slip is reported.
- R8: A frame pulse that arrives right after the last cell of a frame raises no slip.
- R9: A frame pulse at any other position while aligned sets the count back to cell 0 of channel 0 and pulses `slip_o` for one cycle. It also cancels any pending transmit load, so channel 0 after the resync is not driven. The partly received byte is discarded.
- R10: In channel 31 the transmit request names channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Double-rate bit clock from the bus |
| fsync_n_i | input | 1 | Active-low frame pulse from the bus |
| sdi_i | input | 1 | Serial receive data |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Output enable for the transmit line (0 = high impedance) |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_byte_o | output | 8 | Received byte |
| rx_ch_o | output | 5 | Channel of the received byte |
| tx_req_o | output | 1 | One-cycle request for the next channel's transmit byte |
| tx_req_ch_o | output | 5 | Channel being requested |
| tx_load_i | input | 1 | Load strobe for the requested byte |
| tx_byte_i | input | 8 | Transmit byte for the requested channel |
| tx_drive_i | input | 1 | 1 = drive the line during the requested channel |
| slip_o | output | 1 | One-cycle pulse when the frame pulse arrived out of place |

## Verification
The assertions check several properties on every cycle. The receive strobe, the transmit request and the slip flag must each last only one cycle. The output enable may rise only on the first cell of a channel. Before alignment the block must be silent. A cycle-accurate model in the bench is needed for the rest. It checks the received byte values and channel numbers, the serial output bit by bit at its three-quarter point, and which channels are driven. It also checks that a missing pulse changes nothing and that an early pulse realigns to channel 0 and raises one slip.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int DEF_CHANNELS  = 32;
  localparam int DEF_CELL_BITS = 8;
  localparam int DEF_SYNC      = 2;
endpackage

// File: rtl/tdm_in_sync.sv
module tdm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fsync_n_i,
  input  logic sd_i,
  output logic fall_o,
  output logic rise_o,
  output logic fsync_low_o,
  output logic sd_o
);
  // bit 2 = bit clock, bit 1 = frame pulse (active low), bit 0 = data
  logic [2:0] chain [STAGES];
  logic       bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 3'b010;
      bclk_q <= 1'b0;
    end else begin
      chain[0] <= {bclk_i, fsync_n_i, sd_i};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      bclk_q <= chain[STAGES-1][2];
    end
  end

  assign fall_o      = bclk_q & ~chain[STAGES-1][2];
  assign rise_o      = ~bclk_q & chain[STAGES-1][2];
  assign fsync_low_o = ~chain[STAGES-1][1];
  assign sd_o        = chain[STAGES-1][0];
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_i,
  input  logic             fsync_low_i,
  output logic [POS_W-1:0] pos_o,
  output logic             locked_o,
  output logic             cell_start_o,
  output logic             slip_o
);
  localparam logic [POS_W-1:0] LAST_POS = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o        <= '0;
      locked_o     <= 1'b0;
      cell_start_o <= 1'b0;
      slip_o       <= 1'b0;
    end else begin
      cell_start_o <= 1'b0;
      slip_o       <= 1'b0;
      if (fall_i) begin
        if (fsync_low_i) begin
          pos_o        <= '0;
          slip_o       <= locked_o && (pos_o != LAST_POS);
          locked_o     <= 1'b1;
          cell_start_o <= 1'b1;
        end else begin
          pos_o        <= pos_o + 1'b1;
          cell_start_o <= locked_o & pos_o[0];
        end
      end
    end
  end

  assert_slip_single_R9: assert property (@(posedge clk) disable iff (rst)
    slip_o |=> !slip_o);
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int BITS  = 8,
  parameter int BIT_W = 3,
  parameter int CH_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_i,
  input  logic            sd_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic [CH_W-1:0] ch_idx_i,
  output logic            rx_valid_o,
  output logic [BITS-1:0] rx_byte_o,
  output logic [CH_W-1:0] rx_ch_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);
  logic [BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      rx_ch_o    <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sample_i) begin
        sh <= {sh[BITS-2:0], sd_i};
        if (bit_idx_i == LAST_BIT) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {sh[BITS-2:0], sd_i};
          rx_ch_o    <= ch_idx_i;
        end
      end
    end
  end

  assert_rx_single_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int BITS  = 8,
  parameter int BIT_W = 3,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_start_i,
  input  logic             clear_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic [CH_W-1:0]  ch_idx_i,
  input  logic             load_i,
  input  logic [BITS-1:0]  byte_i,
  input  logic             drive_i,
  output logic             sd_o,
  output logic             oe_o,
  output logic             req_o,
  output logic [CH_W-1:0]  req_ch_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);
  logic [BITS-1:0] hold;
  logic            hold_drv;
  logic [BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      hold_drv <= 1'b0;
      sh       <= '0;
      sd_o     <= 1'b0;
      oe_o     <= 1'b0;
      req_o    <= 1'b0;
      req_ch_o <= '0;
    end else begin
      req_o <= 1'b0;
      if (load_i) begin
        hold     <= byte_i;
        hold_drv <= drive_i;
      end
      if (cell_start_i) begin
        if (bit_idx_i == '0) begin
          sh       <= hold;
          sd_o     <= hold[BITS-1];
          oe_o     <= hold_drv;
          hold_drv <= 1'b0;
        end else begin
          sh   <= {sh[BITS-2:0], 1'b0};
          sd_o <= sh[BITS-2];
        end
        if (bit_idx_i == LAST_BIT) begin
          req_o    <= 1'b1;
          req_ch_o <= ch_idx_i + 1'b1;
        end
      end
      if (clear_i) begin
        oe_o     <= 1'b0;
        hold_drv <= 1'b0;
      end
    end
  end

  assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  assert_oe_rise_on_cell_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> (bit_idx_i == '0));
endmodule

// File: rtl/tdm_channel_port.sv
module tdm_channel_port
  import tdm_pkg::*;
#(
  parameter int CHANNELS    = DEF_CHANNELS,
  parameter int CELL_BITS   = DEF_CELL_BITS,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int CH_W       = $clog2(CHANNELS),
  localparam int BIT_W      = $clog2(CELL_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk_i,
  input  logic                 fsync_n_i,
  input  logic                 sdi_i,
  output logic                 tx_sd_o,
  output logic                 tx_oe_o,
  output logic                 rx_valid_o,
  output logic [CELL_BITS-1:0] rx_byte_o,
  output logic [CH_W-1:0]      rx_ch_o,
  output logic                 tx_req_o,
  output logic [CH_W-1:0]      tx_req_ch_o,
  input  logic                 tx_load_i,
  input  logic [CELL_BITS-1:0] tx_byte_i,
  input  logic                 tx_drive_i,
  output logic                 slip_o
);
  localparam int POS_W = CH_W + BIT_W + 1;

  logic             fall, rise, fsync_low, sd;
  logic [POS_W-1:0] pos;
  logic             locked, cell_start;
  logic [BIT_W-1:0] bit_idx;
  logic [CH_W-1:0]  ch_idx;
  logic             sample;

  tdm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fsync_n_i(fsync_n_i), .sd_i(sdi_i),
    .fall_o(fall), .rise_o(rise), .fsync_low_o(fsync_low), .sd_o(sd));

  tdm_frame_timer #(.POS_W(POS_W)) u_timer (
    .clk(clk), .rst(rst), .fall_i(fall), .fsync_low_i(fsync_low),
    .pos_o(pos), .locked_o(locked), .cell_start_o(cell_start), .slip_o(slip_o));

  assign bit_idx = pos[BIT_W:1];
  assign ch_idx  = pos[POS_W-1:BIT_W+1];
  assign sample  = rise & locked & pos[0];

  tdm_rx_deser #(.BITS(CELL_BITS), .BIT_W(BIT_W), .CH_W(CH_W)) u_rx (
    .clk(clk), .rst(rst), .sample_i(sample), .sd_i(sd),
    .bit_idx_i(bit_idx), .ch_idx_i(ch_idx),
    .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o), .rx_ch_o(rx_ch_o));

  tdm_tx_ser #(.BITS(CELL_BITS), .BIT_W(BIT_W), .CH_W(CH_W)) u_tx (
    .clk(clk), .rst(rst), .cell_start_i(cell_start), .clear_i(slip_o),
    .bit_idx_i(bit_idx), .ch_idx_i(ch_idx),
    .load_i(tx_load_i), .byte_i(tx_byte_i), .drive_i(tx_drive_i),
    .sd_o(tx_sd_o), .oe_o(tx_oe_o), .req_o(tx_req_o), .req_ch_o(tx_req_ch_o));

  assert_quiet_unlocked_R2: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (!rx_valid_o && !tx_req_o && !tx_oe_o));
  assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid_o && tx_req_o));
endmodule

// File: tb/tdm_channel_port_test.sv
module tdm_channel_port_test;
  logic clk = 1'b0;
  logic rst;
  logic bclk, fsn, sdi;
  logic tx_sd, tx_oe, rx_valid, tx_req, slip, tx_load, tx_drive;
  logic [7:0] rx_byte, tx_byte;
  logic [4:0] rx_ch, tx_req_ch;

  always #2.5 clk = ~clk;

  tdm_channel_port uut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_n_i(fsn), .sdi_i(sdi),
    .tx_sd_o(tx_sd), .tx_oe_o(tx_oe), .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .rx_ch_o(rx_ch), .tx_req_o(tx_req), .tx_req_ch_o(tx_req_ch),
    .tx_load_i(tx_load), .tx_byte_i(tx_byte), .tx_drive_i(tx_drive), .slip_o(slip));

  int n_chk = 0, n_fail = 0;
  int n_rx = 0, n_req = 0, got_slip = 0, exp_slip = 0;
  int bp = 100, fr = 0, cur_bp = 0;
  bit m_locked = 0, start_next = 0, done = 0, mid_done = 0;
  bit pend_valid = 0, pend_drv = 0, act_drv = 0;
  int pend_ch = 0;
  logic [7:0] pend_byte = 0, act_byte = 0;
  int exp_q[$];
  localparam logic [31:0] DRIVE_MASK = 32'hF0F0_A5C3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rxb(input int ch, input int f);
    return 8'((ch * 37 + f * 11 + 5) & 255);
  endfunction
  function automatic logic [7:0] txb(input int ch, input int f);
    return 8'((ch * 53 + f * 7 + 60) & 255);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // transmit responder and request checker (R4, R10)
  always @(negedge clk) begin
    tx_load = 1'b0;
    if (!rst && tx_req) begin
      int exp_ch;
      n_req++;
      exp_ch = ((cur_bp >> 4) + 1) % 32;
      chk(((cur_bp >> 1) % 8) == 7, "R4 request cell", (cur_bp >> 1) % 8, 7);
      chk(tx_req_ch == 5'(exp_ch), exp_ch == 0 ? "R10 wrap index" : "R4 request index",
          tx_req_ch, exp_ch);
      pend_valid = 1;
      pend_ch    = tx_req_ch;
      pend_byte  = txb(tx_req_ch, fr);
      pend_drv   = DRIVE_MASK[tx_req_ch];
      tx_load    = 1'b1;
      tx_byte    = pend_byte;
      tx_drive   = pend_drv;
    end
  end

  // receive and slip monitors
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      n_rx++;
      if (exp_q.size() == 0) chk(0, "R2 unexpected strobe", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(rx_ch == 5'(e >> 8), "R3 channel", rx_ch, e >> 8);
        chk(rx_byte == 8'(e & 255), "R3 byte", rx_byte, e & 255);
      end
    end
    if (!rst && slip) begin
      chk(got_slip < exp_slip, "R9 slip pulse", got_slip + 1, exp_slip);
      got_slip++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1; bclk = 0; fsn = 1; sdi = 0; tx_load = 0; tx_byte = 0; tx_drive = 0;
    repeat (5) @(negedge clk);
    chk(!rx_valid && !tx_req && !tx_oe && !slip, "R1 reset outputs",
        {rx_valid, tx_req, tx_oe, slip}, 0);
    rst = 0;
    while (!(m_locked && fr == 8)) begin
      int k, ch;
      logic [7:0] b;
      if (start_next) begin
        if (m_locked && bp != 511) begin
          exp_slip++;
          pend_valid = 0;
        end
        if (!m_locked) begin
          chk(n_rx == 0 && n_req == 0 && got_slip == 0, "R2 silent before lock",
              n_rx + n_req, 0);
          m_locked = 1;
          fr = 0;
        end else fr++;
        bp = 0;
      end else begin
        bp = (bp + 1) % 512;
        if (m_locked && bp == 0) fr++;
      end
      cur_bp = bp;
      k  = (bp >> 1) % 8;
      ch = bp >> 4;
      if (m_locked && (bp % 16) == 0) begin
        act_drv  = pend_valid && pend_drv && (pend_ch == ch);
        act_byte = pend_byte;
        pend_valid = 0;
      end
      if (bp % 2 == 0) begin
        b = rxb(ch, fr);
        sdi = b[7 - k];
      end
      bclk = 0;
      repeat (4) @(negedge clk);
      bclk = 1;
      if (m_locked && (bp % 2) == 1 && k == 7) exp_q.push_back(ch * 256 + rxb(ch, fr));
      start_next = (bp == 511 && !(m_locked && fr == 3)) || (m_locked && fr == 5 && bp == 199);
      fsn = start_next ? 1'b0 : 1'b1;
      repeat (3) @(negedge clk);
      if (bp % 2 == 1) begin
        bit e_oe;
        e_oe = m_locked && act_drv;
        chk(tx_oe == e_oe, e_oe ? "R5 enable" : "R6 disabled", tx_oe, e_oe);
        if (e_oe) chk(tx_sd == act_byte[7 - k], "R5 data bit", tx_sd, act_byte[7 - k]);
      end
      @(negedge clk);
      if (m_locked && fr == 4 && bp == 0 && !mid_done) begin
        mid_done = 1;
        chk(got_slip == 0, "R7 R8 no slip on good or missing pulse", got_slip, 0);
      end
    end
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
    chk(got_slip == exp_slip && exp_slip == 1, "R9 slip count", got_slip, 1);
    chk(n_rx > 0 && n_req > 0, "R3 R4 activity", n_rx, 1);
    finish_run();
  end
endmodule